// File: doc/BRIEF.md
# Tile List Segment Allocator

This block builds, for every screen tile, separate linked lists of object pointers in one bounded memory region. A request names a tile, a list kind and a 32-bit object pointer. The block keeps a table with one entry per tile and kind. Each entry holds the address of the open segment and how many pointers it contains. When an append arrives for a list that has no segment yet, a segment is taken from a shared allocation position. When a segment already holds all its pointer slots, a new segment is taken and the last word of the old one is written with the byte address of the new one.

The allocation position can move toward higher or lower addresses, and it stops at a limit. If a new segment would cross that limit, the block writes nothing and raises a one-cycle overrun pulse. After that it refuses every further allocation until a full init or a reinit. Init clears all lists and moves the position back to the start. Reinit clears the lists but keeps the position, so registration can continue in fresh memory. Memory is reached through two registered write ports: one for pointer words and one for link words.

Top module: `tile_list_alloc`

## Requirements
- R1: Kind t (0 opaque polygons, 1 opaque modifiers, 2 translucent polygons, 3 translucent modifiers, 4 punch-through) takes its size code from `cfg_seg_code_i[2t+1:2t]`. Code 0 disables the kind, so an append to it writes nothing. Codes 1, 2 and 3 give segments of 8, 16 and 32 words (32, 64 and 128 bytes), which hold 7, 15 and 31 pointers.
- R2: An append whose kind code is 5, 6 or 7 is ignored: nothing is written and the position does not change.
- R3: The first append to an empty list, with upward growth, opens a segment whose base is the current position. The position then advances by the segment size in bytes. `alloc_pos_o` shows the position as a byte address.
- R4: An append to a list whose open segment has a free slot writes the pointer at segment base + 4 × (pointers already stored). The write appears on the pointer port in the cycle after the request.
- R5: An append to a list whose segment holds all its pointers opens a new segment. In the same output cycle, the link port writes the byte address of the new base into the last word of the old segment, and the pointer goes into the first word of the new segment.
- R6: With downward growth (`cfg_dir_down_i`=1), a new segment has base = position − segment bytes, and the position becomes that base.
- R7: An allocation that would cross the limit is refused. Upward, this means the segment end would pass `cfg_limit_i`×128. Downward, it means the base would fall below `cfg_limit_i`×128. When refused, nothing is written, the position is unchanged and `ovr_irq_o` is high for exactly one cycle.
- R8: After an overrun, every later request that needs an allocation is refused, with no write and no further pulse, until init or reinit. Appends into segments that still have room are still written.
- R9: Init sets the position to `cfg_start_i`×128, empties all lists and clears the overrun lock. An append in the same cycle is dropped.
- R10: Reinit empties all lists and clears the overrun lock but keeps the position. An append in the same cycle is dropped.
- R11: Synchronous reset has the effect of init and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Full initialise pulse |
| reinit_i | input | 1 | List-only initialise pulse |
| cfg_dir_down_i | input | 1 | 1: segments allocated downward |
| cfg_start_i | input | ADDR_W-7 | Allocation start, in 128-byte blocks |
| cfg_limit_i | input | ADDR_W-7 | Allocation limit, in 128-byte blocks |
| cfg_seg_code_i | input | 10 | Two-bit size code per list kind |
| app_valid_i | input | 1 | Append request |
| app_tile_i | input | TILE_W | Tile index |
| app_kind_i | input | 3 | List kind |
| app_obj_i | input | OBJ_W | Object pointer to store |
| ptr_we_o | output | 1 | Pointer word write enable |
| ptr_addr_o | output | ADDR_W | Pointer word byte address |
| ptr_data_o | output | OBJ_W | Pointer word data |
| link_we_o | output | 1 | Link word write enable |
| link_addr_o | output | ADDR_W | Link word byte address |
| link_data_o | output | OBJ_W | Byte address of the next segment |
| ovr_irq_o | output | 1 | One-cycle overrun pulse |
| alloc_pos_o | output | ADDR_W | Current allocation position, byte address |

## Verification
A wrong fill count or base in the table shows up on the pointer port at the next append to that tile and kind. It can also show up as a link written one slot early or late. A wrong allocation position is visible on `alloc_pos_o` in the cycle after the grant, and also on the base of the next segment opened by any tile. A lock that is wrongly set or cleared shows at the next request that needs a segment: it appears as an extra or missing overrun pulse, or as a write where none belongs. The bench compares every output against a behavioural model on every clock, so any such divergence is reported at the first cycle it reaches a port.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int NKIND = 5;
  localparam int SEGW_W = 6;
  localparam int CNT_W = 5;

  typedef enum logic [2:0] {
    K_OPQ_POLY = 3'd0,
    K_OPQ_MOD  = 3'd1,
    K_TRN_POLY = 3'd2,
    K_TRN_MOD  = 3'd3,
    K_PUNCH    = 3'd4
  } kind_e;

  function automatic logic [SEGW_W-1:0] code_to_words(input logic [1:0] code);
    logic [SEGW_W-1:0] w;
    case (code)
      2'd1:    w = 6'd8;
      2'd2:    w = 6'd16;
      2'd3:    w = 6'd32;
      default: w = 6'd0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/tla_seg_decode.sv
module tla_seg_decode
  import tla_pkg::*;
(
  input  logic [2*NKIND-1:0] seg_code_i,
  input  logic [2:0]         kind_i,
  output logic               kind_ok_o,
  output logic [SEGW_W-1:0]  seg_words_o
);
  logic [SEGW_W-1:0] words [NKIND];

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign words[k] = code_to_words(seg_code_i[2*k +: 2]);
  end

  always_comb begin
    kind_ok_o   = (kind_i < 3'(NKIND));
    seg_words_o = '0;
    for (int k = 0; k < NKIND; k++) begin
      if (kind_i == 3'(k)) seg_words_o = words[k];
    end
  end
endmodule

// File: rtl/tla_alloc_ptr.sv
module tla_alloc_ptr
  import tla_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              reinit_i,
  input  logic              dir_down_i,
  input  logic [AW-1:0]     start_w_i,
  input  logic [AW-1:0]     limit_w_i,
  input  logic              req_i,
  input  logic [SEGW_W-1:0] seg_words_i,
  output logic [AW-1:0]     new_base_o,
  output logic              fits_o,
  output logic              ovr_ev_o,
  output logic [AW-1:0]     pos_o
);
  logic [AW-1:0] pos_q;
  logic          lock_q;
  logic [AW:0]   sum_up;
  logic [AW:0]   diff_dn;
  logic          room;
  logic [AW-1:0] pos_nxt;

  always_comb begin
    sum_up  = {1'b0, pos_q} + (AW+1)'(seg_words_i);
    diff_dn = {1'b0, pos_q} - (AW+1)'(seg_words_i);
    if (dir_down_i) begin
      room       = !diff_dn[AW] && (diff_dn[AW-1:0] >= limit_w_i);
      new_base_o = diff_dn[AW-1:0];
      pos_nxt    = diff_dn[AW-1:0];
    end else begin
      room       = (sum_up <= {1'b0, limit_w_i});
      new_base_o = pos_q;
      pos_nxt    = sum_up[AW-1:0];
    end
    fits_o   = room && !lock_q;
    ovr_ev_o = req_i && !room && !lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      pos_q  <= start_w_i;
      lock_q <= 1'b0;
    end else if (reinit_i) begin
      lock_q <= 1'b0;
    end else if (req_i) begin
      if (fits_o)        pos_q  <= pos_nxt;
      else if (ovr_ev_o) lock_q <= 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/tla_list_table.sv
module tla_list_table
  import tla_pkg::*;
#(
  parameter int ENTRIES = 80,
  parameter int AW      = 22,
  parameter int IDX_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [AW-1:0]    rd_base_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [AW-1:0]    wr_base_i,
  input  logic [CNT_W-1:0] wr_cnt_i
);
  localparam int EW = AW + CNT_W;

  logic [EW-1:0]      mem [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [EW-1:0]      rd_word;

  always_ff @(posedge clk) begin
    if (we_i) mem[wr_idx_i] <= {wr_base_i, wr_cnt_i};
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  vld_q <= '0;
    else if (we_i)     vld_q[wr_idx_i] <= 1'b1;
  end

  always_comb begin
    if (int'(rd_idx_i) < ENTRIES) begin
      rd_word    = mem[rd_idx_i];
      rd_valid_o = vld_q[rd_idx_i];
    end else begin
      rd_word    = '0;
      rd_valid_o = 1'b0;
    end
  end

  assign rd_base_o = rd_word[EW-1:CNT_W];
  assign rd_cnt_o  = rd_word[CNT_W-1:0];
endmodule

// File: rtl/tile_list_alloc.sv
module tile_list_alloc
  import tla_pkg::*;
#(
  parameter int TILES  = 16,
  parameter int ADDR_W = 24,
  parameter int OBJ_W  = 32,
  parameter int TILE_W = (TILES > 1) ? $clog2(TILES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init_i,
  input  logic                reinit_i,
  input  logic                cfg_dir_down_i,
  input  logic [ADDR_W-8:0]   cfg_start_i,
  input  logic [ADDR_W-8:0]   cfg_limit_i,
  input  logic [2*NKIND-1:0]  cfg_seg_code_i,
  input  logic                app_valid_i,
  input  logic [TILE_W-1:0]   app_tile_i,
  input  logic [2:0]          app_kind_i,
  input  logic [OBJ_W-1:0]    app_obj_i,
  output logic                ptr_we_o,
  output logic [ADDR_W-1:0]   ptr_addr_o,
  output logic [OBJ_W-1:0]    ptr_data_o,
  output logic                link_we_o,
  output logic [ADDR_W-1:0]   link_addr_o,
  output logic [OBJ_W-1:0]    link_data_o,
  output logic                ovr_irq_o,
  output logic [ADDR_W-1:0]   alloc_pos_o
);
  localparam int AW      = ADDR_W - 2;
  localparam int ENTRIES = TILES * NKIND;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic              clr;
  logic              kind_ok;
  logic [SEGW_W-1:0] seg_words;
  logic [2:0]        kind_sel;
  logic [IDX_W-1:0]  idx;
  logic              rd_valid;
  logic [AW-1:0]     rd_base;
  logic [CNT_W-1:0]  rd_cnt;
  logic [CNT_W-1:0]  slots;
  logic              en, seg_full, need_new, fill, grant;
  logic [AW-1:0]     new_base, pos_w, ptr_w;
  logic              fits, ovr_ev;
  logic [AW-1:0]     tbl_base;
  logic [CNT_W-1:0]  tbl_cnt;

  assign clr = init_i || reinit_i;

  tla_seg_decode u_dec (
    .seg_code_i (cfg_seg_code_i),
    .kind_i     (app_kind_i),
    .kind_ok_o  (kind_ok),
    .seg_words_o(seg_words)
  );

  assign kind_sel = kind_ok ? app_kind_i : 3'd0;
  assign idx = IDX_W'(app_tile_i) * IDX_W'(NKIND) + IDX_W'(kind_sel);

  tla_list_table #(.ENTRIES(ENTRIES), .AW(AW), .IDX_W(IDX_W)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .rd_idx_i  (idx),
    .rd_valid_o(rd_valid),
    .rd_base_o (rd_base),
    .rd_cnt_o  (rd_cnt),
    .we_i      (fill || grant),
    .wr_idx_i  (idx),
    .wr_base_i (tbl_base),
    .wr_cnt_i  (tbl_cnt)
  );

  tla_alloc_ptr #(.AW(AW)) u_alloc (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_i),
    .reinit_i   (reinit_i),
    .dir_down_i (cfg_dir_down_i),
    .start_w_i  ({cfg_start_i, 5'd0}),
    .limit_w_i  ({cfg_limit_i, 5'd0}),
    .req_i      (need_new),
    .seg_words_i(seg_words),
    .new_base_o (new_base),
    .fits_o     (fits),
    .ovr_ev_o   (ovr_ev),
    .pos_o      (pos_w)
  );

  always_comb begin
    en       = app_valid_i && !clr && kind_ok && (seg_words != '0);
    slots    = CNT_W'(seg_words - 6'd1);
    seg_full = rd_valid && (rd_cnt == slots);
    need_new = en && (!rd_valid || seg_full);
    fill     = en && rd_valid && !seg_full;
    grant    = need_new && fits;
    tbl_base = grant ? new_base : rd_base;
    tbl_cnt  = grant ? CNT_W'(1) : rd_cnt + CNT_W'(1);
    ptr_w    = fill ? rd_base + AW'(rd_cnt) : new_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_we_o    <= 1'b0;
      link_we_o   <= 1'b0;
      ovr_irq_o   <= 1'b0;
      ptr_addr_o  <= '0;
      ptr_data_o  <= '0;
      link_addr_o <= '0;
      link_data_o <= '0;
    end else begin
      ptr_we_o   <= fill || grant;
      link_we_o  <= grant && rd_valid;
      ovr_irq_o  <= ovr_ev && need_new;
      ptr_addr_o <= {ptr_w, 2'b00};
      ptr_data_o <= app_obj_i;
      link_addr_o <= {rd_base + AW'(slots), 2'b00};
      link_data_o <= OBJ_W'({new_base, 2'b00});
    end
  end

  assign alloc_pos_o = {pos_w, 2'b00};
endmodule

// File: rtl/tla_chk.sv
module tla_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              init_i,
  input logic              reinit_i,
  input logic              ptr_we_o,
  input logic              link_we_o,
  input logic              ovr_irq_o,
  input logic [ADDR_W-1:0] alloc_pos_o
);
  // R5
  link_with_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> ptr_we_o);

  // R7
  ovr_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_irq_o |-> !ptr_we_o && !link_we_o);

  // R8
  ovr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_irq_o |=> !ovr_irq_o);

  // R9
  clr_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    (init_i || reinit_i) |=> !ptr_we_o && !link_we_o && !ovr_irq_o);

  // R3
  pos_moves_only_on_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    (!ptr_we_o && !$past(init_i)) |-> alloc_pos_o == $past(alloc_pos_o));
endmodule

bind tile_list_alloc tla_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .init_i     (init_i),
  .reinit_i   (reinit_i),
  .ptr_we_o   (ptr_we_o),
  .link_we_o  (link_we_o),
  .ovr_irq_o  (ovr_irq_o),
  .alloc_pos_o(alloc_pos_o)
);

// File: tb/tb_tile_list_alloc.sv
module tb_tile_list_alloc;
  localparam int TILES = 16;
  localparam int ADDR_W = 24;
  localparam int OBJ_W = 32;
  localparam int TILE_W = 4;
  localparam int NENT = TILES * 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_i = 0, reinit_i = 0, cfg_dir_down_i = 0;
  logic [ADDR_W-8:0] cfg_start_i = 17'd4, cfg_limit_i = 17'd8;
  logic [9:0] cfg_seg_code_i = 10'b01_10_11_00_01;
  logic app_valid_i = 0;
  logic [TILE_W-1:0] app_tile_i = '0;
  logic [2:0] app_kind_i = '0;
  logic [OBJ_W-1:0] app_obj_i = '0;
  logic ptr_we_o, link_we_o, ovr_irq_o;
  logic [ADDR_W-1:0] ptr_addr_o, link_addr_o, alloc_pos_o;
  logic [OBJ_W-1:0] ptr_data_o, link_data_o;

  always #5 clk = ~clk;

  tile_list_alloc #(.TILES(TILES), .ADDR_W(ADDR_W), .OBJ_W(OBJ_W)) dut (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural model (word addresses)
  bit m_vld [NENT];
  int m_base [NENT];
  int m_cnt [NENT];
  int m_pos;
  bit m_lock;
  bit e_pw, e_lw, e_irq;
  int e_pa, e_la, e_ld;
  logic [31:0] e_pd;
  int obj_n = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear(input bit full);
    foreach (m_vld[i]) m_vld[i] = 0;
    m_lock = 0;
    if (full) m_pos = int'(cfg_start_i) * 32;
  endtask

  task automatic step(input bit v, input int tile, input int kind, input bit ini, input bit rein);
    int code, sw, k, slots, nb, np;
    bit ok;
    obj_n++;
    app_valid_i = v; app_tile_i = TILE_W'(tile); app_kind_i = 3'(kind);
    app_obj_i = 32'hA500_0000 + 32'(obj_n);
    init_i = ini; reinit_i = rein;
    e_pw = 0; e_lw = 0; e_irq = 0; e_pa = 0; e_la = 0; e_ld = 0; e_pd = app_obj_i;
    if (ini) model_clear(1);
    else if (rein) model_clear(0);
    else if (v) begin
      code = (kind < 5) ? int'(cfg_seg_code_i[2*kind +: 2]) : 0;
      sw = (code == 0) ? 0 : (4 << code);
      if (sw != 0) begin
        k = tile * 5 + kind;
        slots = sw - 1;
        if (m_vld[k] && m_cnt[k] < slots) begin
          e_pw = 1; e_pa = (m_base[k] + m_cnt[k]) * 4; m_cnt[k]++;
        end else if (!m_lock) begin
          if (cfg_dir_down_i) begin np = m_pos - sw; nb = np; ok = (np >= int'(cfg_limit_i) * 32); end
          else begin nb = m_pos; np = m_pos + sw; ok = (np <= int'(cfg_limit_i) * 32); end
          if (!ok) begin e_irq = 1; m_lock = 1; end
          else begin
            if (m_vld[k]) begin e_lw = 1; e_la = (m_base[k] + slots) * 4; e_ld = nb * 4; end
            e_pw = 1; e_pa = nb * 4;
            m_base[k] = nb; m_cnt[k] = 1; m_vld[k] = 1; m_pos = np;
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    app_valid_i = 0; init_i = 0; reinit_i = 0;
    check("R4 ptr_we", ptr_we_o, e_pw);
    if (e_pw) begin
      check("R4 ptr_addr", ptr_addr_o, e_pa);
      check("R4 ptr_data", ptr_data_o, e_pd);
    end
    check("R5 link_we", link_we_o, e_lw);
    if (e_lw) begin
      check("R5 link_addr", link_addr_o, e_la);
      check("R5 link_data", link_data_o, e_ld);
    end
    check("R7 ovr_irq", ovr_irq_o, e_irq);
    check("R3 alloc_pos", alloc_pos_o, m_pos * 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear(1);
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 pos after reset", alloc_pos_o, 24'h200);
    check("R11 ptr_we after reset", ptr_we_o, 0);
    check("R11 irq after reset", ovr_irq_o, 0);
    step(0, 0, 0, 1, 0);
    // R3 first allocation upward
    step(1, 0, 0, 0, 0);
    check("R3 first base", ptr_addr_o, 24'h200);
    check("R3 pos advance", alloc_pos_o, 24'h220);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0);
    check("R4 seventh slot", ptr_addr_o, 24'h218);
    // R5 segment full -> link
    step(1, 0, 0, 0, 0);
    check("R5 link addr", link_addr_o, 24'h21C);
    check("R5 link data", link_data_o, 32'h220);
    check("R5 new ptr", ptr_addr_o, 24'h220);
    // R1 disabled kind, R2 illegal kinds
    step(1, 0, 1, 0, 0);
    check("R1 disabled kind no write", ptr_we_o, 0);
    step(1, 3, 5, 0, 0);
    check("R2 kind5 no write", ptr_we_o, 0);
    step(1, 3, 7, 0, 0);
    check("R2 kind7 pos", alloc_pos_o, 24'h240);
    // R1 sizes 128 and 64 bytes
    step(1, 1, 2, 0, 0);
    check("R1 32-word segment", alloc_pos_o, 24'h2C0);
    step(1, 2, 3, 0, 0);
    check("R1 16-word segment", alloc_pos_o, 24'h300);
    step(1, 5, 2, 0, 0);
    step(1, 6, 0, 0, 0);
    // R7 overrun
    step(1, 7, 2, 0, 0);
    check("R7 irq", ovr_irq_o, 1);
    check("R7 pos kept", alloc_pos_o, 24'h3A0);
    // R8 locked
    step(1, 8, 2, 0, 0);
    check("R8 no second irq", ovr_irq_o, 0);
    step(1, 6, 0, 0, 0);
    check("R8 fill still written", ptr_addr_o, 24'h384);
    step(1, 9, 0, 0, 0);
    check("R8 alloc refused", ptr_we_o, 0);
    // R10 reinit
    step(0, 0, 0, 0, 1);
    check("R10 pos kept", alloc_pos_o, 24'h3A0);
    step(1, 0, 0, 0, 0);
    check("R10 no link", link_we_o, 0);
    check("R10 new at pos", ptr_addr_o, 24'h3A0);
    // R9 init drops same-cycle append
    step(1, 0, 0, 1, 0);
    check("R9 dropped", ptr_we_o, 0);
    check("R9 pos start", alloc_pos_o, 24'h200);
    // R6 downward
    cfg_dir_down_i = 1; cfg_start_i = 17'd16; cfg_limit_i = 17'd12;
    step(0, 0, 0, 1, 0);
    step(1, 0, 2, 0, 0);
    check("R6 down base", ptr_addr_o, 24'h780);
    check("R6 down pos", alloc_pos_o, 24'h780);
    step(1, 1, 2, 0, 0);
    step(1, 2, 2, 0, 0);
    step(1, 3, 2, 0, 0);
    check("R6 exact limit", ptr_addr_o, 24'h600);
    step(1, 4, 2, 0, 0);
    check("R7 down irq", ovr_irq_o, 1);
    // random traffic against the model
    cfg_dir_down_i = 0; cfg_start_i = 17'd2; cfg_limit_i = 17'd40;
    step(0, 0, 0, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 199));
      if (r == 0) begin
        cfg_dir_down_i = $urandom_range(0, 1);
        cfg_start_i = cfg_dir_down_i ? 17'd40 : 17'd2;
        cfg_limit_i = cfg_dir_down_i ? 17'd2 : 17'd40;
        cfg_seg_code_i = 10'($urandom);
        step(0, 0, 0, 1, 0);
      end else if (r == 1) step(0, 0, 0, 0, 1);
      else step(r > 20, int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), 0, 0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule